// File: doc/BRIEF.md
# Power-Down and Keep-Alive Sequencer

This block controls one multifunction control pin of a clock generator. A configuration input picks what the pin does. It can act as an active-low power-down request, or as an output enable for a chosen group of clock outputs. In power-down use, the block takes the device through a short sequence. First the outputs are parked low. Once every output driver reports that it is parked, the PLLs and the drivers are switched off. When the pin goes high again, the PLLs are restarted and the outputs stay parked until a lock interval has run out. Only then are the clocks released.

A keep-alive option decides what happens to the volatile configuration registers during the off period. When the option is set, the off period is a power-save state: the register block is told to retain its contents. When the option is clear, the off period is a full power-down, and the register block gets a one-cycle reload pulse on wake-up so that it restores its defaults.

The pin is asynchronous. It passes through a two-flop synchronizer and a debounce filter before it can change the state. The states are RUN, PARK, OFF and LOCK_WAIT. The transitions are named below:

- RUN to PARK is the power-down request.
- PARK to OFF is park complete.
- OFF to LOCK_WAIT is wake.
- LOCK_WAIT to RUN is lock done.
- LOCK_WAIT to PARK is aborted wake.

Top module: `pwr_keepalive_ctrl`

## Requirements
- R1: The pin level seen by the state machine changes only after the synchronized pin has held a new level for DEB_CYCLES (default 4) consecutive clock samples. A pulse on the pin that is shorter than that leaves the state unchanged.
- R2: With pin_is_oe low, a filtered low level in RUN or LOCK_WAIT moves the state to PARK. In PARK, every out_park bit is 1 and every pll_en bit stays 1.
- R3: PARK moves to OFF only in a cycle where every out_parked bit is 1. In OFF, all pll_en bits are 0, and all out_off and out_park bits are 1.
- R4: OFF moves to LOCK_WAIT when the filtered pin is high or when pin_is_oe is 1. LOCK_WAIT lasts exactly LOCK_CYCLES cycles, then moves to RUN. During LOCK_WAIT, pll_en is all 1, out_park is all 1 and out_off is all 0.
- R5: keep_alive is captured on the park-complete transition. If the captured value is 0, cfg_reload is 1 for exactly the first cycle of LOCK_WAIT after OFF, and cfg_retain stays 0. If it is 1, no reload pulse occurs, and cfg_retain is 1 for the whole OFF period.
- R6: With pin_is_oe high, the state stays in RUN. While the filtered pin is low, out_park equals oe_mask, and it is 0 otherwise. pll_en stays all 1.
- R7: After reset the state is LOCK_WAIT, with pll_en all 1, out_park all 1 and cfg_reload 0. RUN follows after LOCK_CYCLES cycles if the pin is high.
- R8: state_code encodes RUN=0, PARK=1, OFF=2 and LOCK_WAIT=3.
- R9: Once in PARK, the sequence completes to OFF even if the pin returns high. A stalled driver holds the state in PARK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pin | input | 1 | Asynchronous multifunction control pin |
| pin_is_oe | input | 1 | 1: the pin is an output enable; 0: the pin is an active-low power-down |
| keep_alive | input | 1 | 1: keep register contents while off |
| oe_mask | input | N_OUT | Outputs that follow the pin in output-enable use |
| out_parked | input | N_OUT | Per-output report that the driver is held low |
| pll_en | output | N_PLL | PLL enables |
| out_park | output | N_OUT | Per-output request to drive low |
| out_off | output | N_OUT | Per-output driver disable |
| cfg_retain | output | 1 | Register block retain request during OFF |
| cfg_reload | output | 1 | One-cycle default-reload pulse to the register block |
| state_code | output | 2 | Current state, encoded as in R8 |

## Verification
The hardest situation to reach from the ports is a PARK state held open by one output driver that never reports parked, while the pin has already gone back high. A close second is a wake that is aborted while the lock timer is still running. The bench models the output drivers itself, and a stall mask keeps selected out_parked bits low. Directed phases hold one bit stalled across a pin rise and then release it. Random segments mix stall masks, short pin glitches around the debounce length and hold times longer than the lock interval. A cycle-level reference model in the bench is compared on every cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PARK = 2'd1,
        ST_OFF  = 2'd2,
        ST_LOCK = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_lvl
);
    localparam int DEB_W = $clog2(DEB_CYCLES + 1);
    localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_CYCLES - 1);

    logic             sync_a;
    logic             sync_b;
    logic [DEB_W-1:0] run_cnt;

    // Two-flop synchronizer, reset to the inactive (high) level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= pin_async;
            sync_b <= sync_a;
        end
    end

    // Debounce: the filtered level follows only after DEB_CYCLES
    // consecutive differing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_lvl <= 1'b1;
            run_cnt <= '0;
        end else if (sync_b == pin_lvl) begin
            run_cnt <= '0;
        end else if (run_cnt == DEB_LAST) begin
            pin_lvl <= sync_b;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int LOCK_CYCLES = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

    logic [LOCK_W-1:0] cnt;

    // Counts while the wait state is active; cleared in every other state,
    // so each entry starts from zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign done = active && (cnt == LOCK_LAST);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwrseq_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int N_PLL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_lvl,
    input  logic             pin_is_oe,
    input  logic             keep_alive,
    input  logic [N_OUT-1:0] oe_mask,
    input  logic             all_parked,
    input  logic             lock_done,
    output pwr_state_e       state,
    output logic [N_PLL-1:0] pll_en,
    output logic [N_OUT-1:0] out_park,
    output logic [N_OUT-1:0] out_off,
    output logic             cfg_retain,
    output logic             cfg_reload
);
    pwr_state_e nxt;
    logic       ka_held;
    logic       pd_req;
    logic       wake;

    assign pd_req = !pin_is_oe && !pin_lvl;
    assign wake   = pin_lvl || pin_is_oe;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (pd_req) nxt = ST_PARK;
            ST_PARK: if (all_parked) nxt = ST_OFF;
            ST_OFF:  if (wake) nxt = ST_LOCK;
            ST_LOCK: begin
                if (pd_req)         nxt = ST_PARK;
                else if (lock_done) nxt = ST_RUN;
            end
        endcase
    end

    // State register with keep-alive capture and reload pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_LOCK;
            ka_held    <= 1'b0;
            cfg_reload <= 1'b0;
        end else begin
            state      <= nxt;
            if (state == ST_PARK && nxt == ST_OFF) begin
                ka_held <= keep_alive;
            end
            cfg_reload <= (state == ST_OFF) && (nxt == ST_LOCK) && !ka_held;
        end
    end

    // Output decode.
    always_comb begin
        pll_en     = '1;
        out_park   = '1;
        out_off    = '0;
        cfg_retain = 1'b0;
        unique case (state)
            ST_RUN:  out_park = pin_is_oe ? (oe_mask & {N_OUT{~pin_lvl}}) : '0;
            ST_PARK: ;
            ST_OFF: begin
                pll_en     = '0;
                out_off    = '1;
                cfg_retain = ka_held;
            end
            ST_LOCK: ;
        endcase
    end
endmodule

// File: rtl/pwr_keepalive_ctrl.sv
module pwr_keepalive_ctrl
    import pwrseq_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int N_PLL       = 4,
    parameter int DEB_CYCLES  = 4,
    parameter int LOCK_CYCLES = 150000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_pin,
    input  logic             pin_is_oe,
    input  logic             keep_alive,
    input  logic [N_OUT-1:0] oe_mask,
    input  logic [N_OUT-1:0] out_parked,
    output logic [N_PLL-1:0] pll_en,
    output logic [N_OUT-1:0] out_park,
    output logic [N_OUT-1:0] out_off,
    output logic             cfg_retain,
    output logic             cfg_reload,
    output logic [1:0]       state_code
);
    logic       pin_lvl;
    logic       lock_done;
    pwr_state_e state;

    pin_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ctl_pin),
        .pin_lvl   (pin_lvl)
    );

    lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_LOCK),
        .done   (lock_done)
    );

    pwr_fsm #(.N_OUT(N_OUT), .N_PLL(N_PLL)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .pin_is_oe  (pin_is_oe),
        .keep_alive (keep_alive),
        .oe_mask    (oe_mask),
        .all_parked (&out_parked),
        .lock_done  (lock_done),
        .state      (state),
        .pll_en     (pll_en),
        .out_park   (out_park),
        .out_off    (out_off),
        .cfg_retain (cfg_retain),
        .cfg_reload (cfg_reload)
    );

    assign state_code = state;
endmodule

// File: rtl/pwr_keepalive_chk.sv
module pwr_keepalive_chk #(
    parameter int N_OUT = 8,
    parameter int N_PLL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_is_oe,
    input logic [N_OUT-1:0] out_parked,
    input logic [N_PLL-1:0] pll_en,
    input logic [N_OUT-1:0] out_park,
    input logic [N_OUT-1:0] out_off,
    input logic             cfg_reload,
    input logic [1:0]       state_code
);
    // R3: PARK never leaves for OFF while a driver is unparked.
    assert_park_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd1 && !(&out_parked)) |=> state_code != 2'd2);

    // R3: OFF is entered only from PARK.
    assert_off_from_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'd1 && state_code != 2'd2) |=> state_code != 2'd2);

    // R4: RUN is reached only through LOCK_WAIT.
    assert_run_from_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'd0 && state_code != 2'd3) |=> state_code != 2'd0);

    // R5: reload pulse lands in LOCK_WAIT just after OFF.
    assert_reload_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reload |-> (state_code == 2'd3 && $past(state_code) == 2'd2));

    // R5: reload lasts one cycle.
    assert_reload_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reload |=> !cfg_reload);

    // R3: a driver is switched off only while parked low.
    assert_off_parked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_off) |-> (&out_park));

    // R3: PLLs stop only together with the drivers.
    assert_pll_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_en != {N_PLL{1'b1}}) |-> (&out_off));

    // R6: output-enable use never leaves RUN.
    assert_oe_stays_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0 && pin_is_oe) |=> state_code == 2'd0);
endmodule

bind pwr_keepalive_ctrl pwr_keepalive_chk #(.N_OUT(N_OUT), .N_PLL(N_PLL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_is_oe  (pin_is_oe),
    .out_parked (out_parked),
    .pll_en     (pll_en),
    .out_park   (out_park),
    .out_off    (out_off),
    .cfg_reload (cfg_reload),
    .state_code (state_code)
);

// File: tb/sim_pwr_keepalive_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_keepalive_ctrl;
    localparam int N_OUT = 8;
    localparam int N_PLL = 4;
    localparam int DEB   = 4;
    localparam int LOCK  = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_pin = 1'b1;
    logic             pin_is_oe = 1'b0;
    logic             keep_alive = 1'b0;
    logic [N_OUT-1:0] oe_mask = '0;
    logic [N_OUT-1:0] out_parked = '0;
    logic [N_OUT-1:0] stall = '0;
    logic [N_PLL-1:0] pll_en;
    logic [N_OUT-1:0] out_park;
    logic [N_OUT-1:0] out_off;
    logic             cfg_retain;
    logic             cfg_reload;
    logic [1:0]       state_code;

    int checks = 0;
    int errors = 0;
    int rel_seen = 0;
    int ret_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_keepalive_ctrl #(.N_OUT(N_OUT), .N_PLL(N_PLL), .DEB_CYCLES(DEB), .LOCK_CYCLES(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .pin_is_oe(pin_is_oe),
        .keep_alive(keep_alive), .oe_mask(oe_mask), .out_parked(out_parked),
        .pll_en(pll_en), .out_park(out_park), .out_off(out_off),
        .cfg_retain(cfg_retain), .cfg_reload(cfg_reload), .state_code(state_code)
    );

    // Reference model built from the requirements (state codes per R8).
    logic       m_s1, m_s2, m_deb, m_ka, m_rel;
    int         m_dc, m_lc;
    logic [1:0] m_st, n_st;
    logic       go_park;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_deb = 1; m_dc = 0; m_lc = 0;
            m_st = 2'd3; m_ka = 0; m_rel = 0;
        end else begin
            go_park = !pin_is_oe && !m_deb;
            case (m_st)
                2'd0: n_st = go_park ? 2'd1 : 2'd0;
                2'd1: n_st = (&out_parked) ? 2'd2 : 2'd1;
                2'd2: n_st = (m_deb || pin_is_oe) ? 2'd3 : 2'd2;
                default: n_st = go_park ? 2'd1 : ((m_lc == LOCK-1) ? 2'd0 : 2'd3);
            endcase
            m_rel = (m_st == 2'd2) && (n_st == 2'd3) && !m_ka;
            if (m_st == 2'd1 && n_st == 2'd2) m_ka = keep_alive;
            m_lc = (m_st == 2'd3) ? m_lc + 1 : 0;
            m_st = n_st;
            if (m_s2 == m_deb) m_dc = 0;
            else if (m_dc == DEB-1) begin m_deb = m_s2; m_dc = 0; end
            else m_dc = m_dc + 1;
            m_s2 = m_s1;
            m_s1 = ctl_pin;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [N_OUT-1:0] e_park;
        if (m_st == 2'd0) e_park = pin_is_oe ? (oe_mask & {N_OUT{~m_deb}}) : '0;
        else              e_park = '1;
        chk("R8 state_code", 32'(state_code), 32'(m_st));
        chk("R3 pll_en", 32'(pll_en), (m_st == 2'd2) ? 32'h0 : 32'hF);
        chk("R2 out_park", 32'(out_park), 32'(e_park));
        chk("R3 out_off", 32'(out_off), (m_st == 2'd2) ? 32'hFF : 32'h0);
        chk("R5 cfg_retain", 32'(cfg_retain), 32'((m_st == 2'd2) && m_ka));
        chk("R5 cfg_reload", 32'(cfg_reload), 32'(m_rel));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            if (cfg_reload) rel_seen++;
            if (cfg_retain) ret_seen++;
            out_parked = out_park & ~stall;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk("R7 reset state LOCK_WAIT", 32'(state_code), 32'd3);
        chk("R7 reset reload low", 32'(cfg_reload), 32'd0);
        rst_n = 1'b1;
        step(LOCK - 1);
        chk("R7 still LOCK_WAIT", 32'(state_code), 32'd3);
        step(1);
        chk("R4 RUN after LOCK_CYCLES", 32'(state_code), 32'd0);

        // R1: a 3-cycle glitch is ignored.
        ctl_pin = 0; step(DEB - 1); ctl_pin = 1; step(12);
        chk("R1 glitch ignored", 32'(state_code), 32'd0);

        // R1/R2: a 4-cycle low is accepted, PARK at the 7th edge.
        ctl_pin = 0; step(DEB); ctl_pin = 1; step(3);
        chk("R2 PARK after debounce", 32'(state_code), 32'd1);
        rel_seen = 0;
        step(LOCK + 10);
        chk("R5 reload pulse count ka=0", 32'(rel_seen), 32'd1);
        chk("R4 back in RUN", 32'(state_code), 32'd0);

        // R9: stalled driver holds PARK across a pin rise.
        stall = 8'h10; ctl_pin = 0; step(12);
        ctl_pin = 1; step(20);
        chk("R9 PARK held by stall", 32'(state_code), 32'd1);
        stall = '0; keep_alive = 1; rel_seen = 0; ret_seen = 0;
        step(LOCK + 10);
        chk("R9 sequence completed", 32'(state_code), 32'd0);
        chk("R5 retain seen ka=1", 32'(ret_seen > 0), 32'd1);
        chk("R5 no reload ka=1", 32'(rel_seen), 32'd0);

        // R6: output-enable use.
        pin_is_oe = 1; oe_mask = 8'h3C; ctl_pin = 0; step(10);
        chk("R6 out_park follows mask", 32'(out_park), 32'h3C);
        chk("R6 stays RUN", 32'(state_code), 32'd0);
        chk("R6 plls on", 32'(pll_en), 32'hF);
        ctl_pin = 1; step(10);
        chk("R6 released", 32'(out_park), 32'h0);
        pin_is_oe = 0;

        // Random segments, checked every cycle against the model.
        for (int s = 0; s < 400; s++) begin
            int hold;
            hold = ($urandom % 6 == 0) ? 30 + $urandom % 40 : 1 + $urandom % 8;
            ctl_pin    = $urandom % 2;
            keep_alive = $urandom % 2;
            pin_is_oe  = ($urandom % 10 == 0);
            oe_mask    = N_OUT'($urandom);
            stall      = ($urandom % 6 == 0) ? N_OUT'($urandom) : '0;
            step(hold);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule